// File: doc/BRIEF.md
# Three-Phase Gate Drive Protection Logic

This block is the digital core of a three-phase half-bridge pre-driver. Each phase has one upper-switch command and one lower-switch command, both active high. The block turns these commands into upper and lower gate enables. A phase whose two commands are both asserted is driven to high impedance, so the two switches of one leg are never on together. Dead time for switching delay is handled outside this block.

Protection comes from three flags, all sampled asynchronously. The first is a bus over-current flag. It turns every gate off and pulls the active-low fault output. Once the flag has gone away, the shutdown lifts by itself after a programmable hold time. The default hold is 30 ms at a 50 MHz clock, which lies inside the allowed 18 to 80 ms window.

The second flag is undervoltage on the main supply. It forces every gate off and releases as soon as the supply recovers, whatever the command state. This flag also covers the lower switches. The third input is one undervoltage flag per phase for the upper-side supply. It blocks only that phase's upper gate, and the block stays in place until that phase's upper command has gone low.

Every input passes through a two-flop synchronizer. Every command then passes through a minimum-width filter, so on or off pulses shorter than the configured width never reach a gate.

Top module: `gate_guard_3ph`

## Requirements
- R1: For each phase, the upper and lower gates are never both enabled. A phase whose two commands are both high has both gates off.
- R2: With no protection active, a phase's gates follow its commands. Upper command alone gives upper gate only. Lower command alone gives lower gate only. No command gives both gates off.
- R3: While the synchronized over-current flag is high, all gates are off and `fault_n` is 0.
- R4: After the over-current flag drops, `fault_n` stays 0 and the gates stay off for CLEAR_CYC cycles. Both then clear with no reset or other input.
- R5: Neither undervoltage flag ever drives `fault_n` low. Only over-current does.
- R6: Main-supply undervoltage forces all gates off. When it clears, gates follow the held commands again without any command change.
- R7: An upper-supply undervoltage on phase p (bit p of `hs_uv`) turns off `hi_gate[p]` only. The other upper gates and all lower gates are unaffected.
- R8: After the upper-supply undervoltage of phase p clears, `hi_gate[p]` stays off until `hi_cmd[p]` has been seen low. A later high command then enables it again.
- R9: A command pulse, high or low, shorter than MIN_PULSE_CYC cycles has no effect on the gates. A pulse of at least MIN_PULSE_CYC cycles is passed through.
- R10: Reset turns all gates off, sets `fault_n` to 1 and clears every upper-side lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | PHASES | Upper-switch commands, bit p = phase p |
| lo_cmd | input | PHASES | Lower-switch commands, bit p = phase p |
| oc_flag | input | 1 | Asynchronous bus over-current flag |
| main_uv | input | 1 | Asynchronous main-supply undervoltage flag |
| hs_uv | input | PHASES | Asynchronous upper-supply undervoltage flags, bit p = phase p |
| hi_gate | output | PHASES | Upper gate enables |
| lo_gate | output | PHASES | Lower gate enables |
| fault_n | output | 1 | Registered active-low fault (0 drives the open-drain pin low) |

## Verification
The bench builds the block with MIN_PULSE_CYC = 3 and CLEAR_CYC = 20. At these values both edges of the clear window, and pulses just below and just above the filter width, can be reached in a few dozen cycles. All 64 command combinations of the three phases are swept and compared against the truth table computed in the bench. Each phase's upper-side lockout is walked through trip, recovery with the command held, command release, and re-enable.

// File: rtl/gg_pkg.sv
package gg_pkg;

    // Command or gate pair of one half-bridge leg
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_pair_t;

    // Over-current shutdown sequencer states
    typedef enum logic [1:0] {
        OC_IDLE = 2'd0,
        OC_TRIP = 2'd1,
        OC_COOL = 2'd2
    } oc_state_e;

    // Gate decision for one leg: shoot-through blocking and protection masks
    function automatic leg_pair_t leg_decide(leg_pair_t cmd, logic kill_all, logic kill_hi);
        leg_pair_t g;
        g.hi = cmd.hi & ~cmd.lo & ~kill_all & ~kill_hi;
        g.lo = cmd.lo & ~cmd.hi & ~kill_all;
        return g;
    endfunction

endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gg_width_filter.sv
module gg_width_filter #(
    parameter int MIN_PULSE_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (MIN_PULSE_CYC <= 1) begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= d;
            end
        end else begin : g_count
            localparam int CW = $clog2(MIN_PULSE_CYC);
            localparam logic [CW-1:0] LAST = CW'(MIN_PULSE_CYC - 1);
            logic [CW-1:0] run;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q   <= 1'b0;
                    run <= '0;
                end else if (d != q) begin
                    if (run == LAST) begin
                        q   <= d;
                        run <= '0;
                    end else begin
                        run <= run + 1'b1;
                    end
                end else begin
                    run <= '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gg_oc_timer.sv
module gg_oc_timer
    import gg_pkg::*;
#(
    parameter int CLEAR_CYC = 1_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_s,
    output logic shut,
    output logic fault_n
);
    localparam int CW = (CLEAR_CYC > 1) ? $clog2(CLEAR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLEAR_CYC - 1);

    oc_state_e     state_q, state_d;
    logic [CW-1:0] hold_cnt;

    always_comb begin
        state_d = state_q;
        case (state_q)
            OC_IDLE: if (oc_s) state_d = OC_TRIP;
            OC_TRIP: if (!oc_s) state_d = OC_COOL;
            OC_COOL: begin
                if (oc_s)                  state_d = OC_TRIP;
                else if (hold_cnt == LAST) state_d = OC_IDLE;
            end
            default: state_d = OC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= OC_IDLE;
            hold_cnt <= '0;
            fault_n  <= 1'b1;
        end else begin
            state_q  <= state_d;
            fault_n  <= (state_d == OC_IDLE);
            if (state_q == OC_COOL && !oc_s) hold_cnt <= hold_cnt + 1'b1;
            else                             hold_cnt <= '0;
        end
    end

    assign shut = (state_q != OC_IDLE);
endmodule

// File: rtl/gg_phase_leg.sv
module gg_phase_leg
    import gg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  leg_pair_t cmd,
    input  logic      hs_uv_s,
    input  logic      kill_all,
    output leg_pair_t gate
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            gate   <= '0;
        end else begin
            lock_q <= hs_uv_s | (lock_q & cmd.hi);
            gate   <= leg_decide(cmd, kill_all, hs_uv_s | lock_q);
        end
    end
endmodule

// File: rtl/gate_guard_3ph.sv
module gate_guard_3ph
    import gg_pkg::*;
#(
    parameter int PHASES        = 3,
    parameter int MIN_PULSE_CYC = 50,
    parameter int CLEAR_CYC     = 1_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHASES-1:0] hi_cmd,
    input  logic [PHASES-1:0] lo_cmd,
    input  logic              oc_flag,
    input  logic              main_uv,
    input  logic [PHASES-1:0] hs_uv,
    output logic [PHASES-1:0] hi_gate,
    output logic [PHASES-1:0] lo_gate,
    output logic              fault_n
);
    localparam int SW = 3 * PHASES + 2;

    logic [SW-1:0]     raw_in, sync_out;
    logic              oc_s, muv_s, oc_shut, kill_all;
    logic [PHASES-1:0] hsuv_s, hi_s, lo_s, hi_f, lo_f;

    assign raw_in = {oc_flag, main_uv, hs_uv, hi_cmd, lo_cmd};

    gg_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    assign {oc_s, muv_s, hsuv_s, hi_s, lo_s} = sync_out;

    gg_oc_timer #(.CLEAR_CYC(CLEAR_CYC)) u_oc (
        .clk     (clk),
        .rst     (rst),
        .oc_s    (oc_s),
        .shut    (oc_shut),
        .fault_n (fault_n)
    );

    assign kill_all = oc_s | oc_shut | muv_s;

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            leg_pair_t cmd_f, gate_p;

            gg_width_filter #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_filt_hi (
                .clk (clk), .rst (rst), .d (hi_s[p]), .q (hi_f[p])
            );
            gg_width_filter #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_filt_lo (
                .clk (clk), .rst (rst), .d (lo_s[p]), .q (lo_f[p])
            );

            assign cmd_f.hi = hi_f[p];
            assign cmd_f.lo = lo_f[p];

            gg_phase_leg u_leg (
                .clk      (clk),
                .rst      (rst),
                .cmd      (cmd_f),
                .hs_uv_s  (hsuv_s[p]),
                .kill_all (kill_all),
                .gate     (gate_p)
            );

            assign hi_gate[p] = gate_p.hi;
            assign lo_gate[p] = gate_p.lo;
        end
    endgenerate
endmodule

// File: rtl/gg_guard_checker.sv
module gg_guard_checker #(
    parameter int PHASES    = 3,
    parameter int CLEAR_CYC = 1_500_000
) (
    input logic              clk,
    input logic              rst,
    input logic              oc_s,
    input logic              muv_s,
    input logic [PHASES-1:0] hsuv_s,
    input logic [PHASES-1:0] hi_gate,
    input logic [PHASES-1:0] lo_gate,
    input logic              fault_n
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                    low_run <= '0;
        else if (oc_s)              low_run <= '0;
        else if (low_run != '1)     low_run <= low_run + 1;
    end

    assert_no_shoot_through_R1: assert property (@(posedge clk) disable iff (rst)
        (hi_gate & lo_gate) == '0);

    assert_oc_shutdown_R3: assert property (@(posedge clk) disable iff (rst)
        oc_s |=> (hi_gate == '0 && lo_gate == '0 && !fault_n));

    assert_clear_delay_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_n) |-> (low_run >= 32'(CLEAR_CYC)));

    assert_fault_only_oc_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> $past(oc_s));

    assert_main_uv_off_R6: assert property (@(posedge clk) disable iff (rst)
        muv_s |=> (hi_gate == '0 && lo_gate == '0));

    assert_hs_uv_off_R7: assert property (@(posedge clk) disable iff (rst)
        (hi_gate & $past(hsuv_s)) == '0);
endmodule

bind gate_guard_3ph gg_guard_checker #(
    .PHASES    (PHASES),
    .CLEAR_CYC (CLEAR_CYC)
) u_guard_chk (
    .clk     (clk),
    .rst     (rst),
    .oc_s    (oc_s),
    .muv_s   (muv_s),
    .hsuv_s  (hsuv_s),
    .hi_gate (hi_gate),
    .lo_gate (lo_gate),
    .fault_n (fault_n)
);

// File: tb/tb_gate_guard_3ph.sv
`timescale 1ns/1ps
module tb_gate_guard_3ph;
    localparam int CLK_PERIOD = 10;
    localparam int FILT  = 3;
    localparam int CLR   = 20;
    localparam int SETTLE = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hi_cmd = '0, lo_cmd = '0, hs_uv = '0;
    logic       oc_flag = 1'b0, main_uv = 1'b0;
    logic [2:0] hi_gate, lo_gate;
    logic       fault_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    gate_guard_3ph #(.PHASES(3), .MIN_PULSE_CYC(FILT), .CLEAR_CYC(CLR)) dut (
        .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .oc_flag(oc_flag), .main_uv(main_uv), .hs_uv(hs_uv),
        .hi_gate(hi_gate), .lo_gate(lo_gate), .fault_n(fault_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // sticky monitors for phase 0 upper gate
    bit mon_en = 0, seen_hi0 = 0, seen_lo0 = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (hi_gate[0])  seen_hi0 = 1;
            if (!hi_gate[0]) seen_lo0 = 1;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        @(negedge clk);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // compare {hi_gate, lo_gate, fault_n} after sampling away from the edge
    task automatic check_out(input string req, input logic [2:0] eh, input logic [2:0] el, input logic ef);
        @(negedge clk);
        n_checks++;
        if ({hi_gate, lo_gate, fault_n} !== {eh, el, ef}) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req,
                     {hi_gate, lo_gate, fault_n}, {eh, el, ef});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        cycles(3);
        check_out("R10 reset state", 3'b000, 3'b000, 1'b1);
        rst = 1'b0;
        cycles(2);

        // R1 R2 exhaustive command sweep
        for (int v = 0; v < 64; v++) begin
            hi_cmd = v[5:3];
            lo_cmd = v[2:0];
            cycles(SETTLE);
            check_out("R1/R2 sweep", hi_cmd & ~lo_cmd, lo_cmd & ~hi_cmd, 1'b1);
        end

        // R6 R5 main undervoltage over several command patterns
        main_uv = 1'b1;
        for (int v = 0; v < 64; v += 9) begin
            hi_cmd = v[5:3];
            lo_cmd = v[2:0];
            cycles(SETTLE);
            check_out("R6/R5 main uv off, no fault", 3'b000, 3'b000, 1'b1);
        end
        hi_cmd = 3'b001;
        lo_cmd = 3'b110;
        cycles(SETTLE);
        main_uv = 1'b0;
        cycles(SETTLE);
        check_out("R6 resume with held commands", 3'b001, 3'b110, 1'b1);

        // R7 R8 R5 upper-side lockout per phase
        for (int p = 0; p < 3; p++) begin
            hi_cmd = 3'b111;
            lo_cmd = 3'b000;
            cycles(SETTLE);
            hs_uv = 3'(1 << p);
            cycles(SETTLE);
            check_out("R7/R5 hs uv masks one upper gate", 3'b111 & ~3'(1 << p), 3'b000, 1'b1);
            hs_uv = 3'b000;
            cycles(SETTLE);
            check_out("R8 lockout holds while command high", 3'b111 & ~3'(1 << p), 3'b000, 1'b1);
            hi_cmd = 3'b111 & ~3'(1 << p);
            cycles(SETTLE);
            hi_cmd = 3'b111;
            cycles(SETTLE);
            check_out("R8 re-enable after command low", 3'b111, 3'b000, 1'b1);
        end

        // R7 lower gates untouched by upper-side undervoltage
        hi_cmd = 3'b000;
        lo_cmd = 3'b111;
        hs_uv  = 3'b111;
        cycles(SETTLE);
        check_out("R7 lower gates unaffected", 3'b000, 3'b111, 1'b1);
        hs_uv = 3'b000;
        cycles(SETTLE);

        // R3 R4 over-current
        hi_cmd = 3'b101;
        lo_cmd = 3'b010;
        cycles(SETTLE);
        oc_flag = 1'b1;
        cycles(6);
        check_out("R3 over-current shutdown", 3'b000, 3'b000, 1'b0);
        oc_flag = 1'b0;
        cycles(CLR / 2);
        check_out("R4 fault held inside clear window", 3'b000, 3'b000, 1'b0);
        cycles(CLR + 10);
        check_out("R4 automatic clear", 3'b101, 3'b010, 1'b1);

        // R9 short on-pulse blocked
        hi_cmd = 3'b000;
        lo_cmd = 3'b000;
        cycles(SETTLE);
        seen_hi0 = 0;
        mon_en = 1;
        hi_cmd = 3'b001;
        cycles(FILT - 1);
        hi_cmd = 3'b000;
        cycles(15);
        mon_en = 0;
        check("R9 short on-pulse ignored", {6'b0, seen_hi0}, 7'b0);

        // R9 long on-pulse passed
        seen_hi0 = 0;
        mon_en = 1;
        hi_cmd = 3'b001;
        cycles(FILT + 2);
        hi_cmd = 3'b000;
        cycles(15);
        mon_en = 0;
        check("R9 long on-pulse passed", {6'b0, seen_hi0}, 7'b1);

        // R9 short off-pulse blocked
        hi_cmd = 3'b001;
        cycles(SETTLE);
        seen_lo0 = 0;
        mon_en = 1;
        hi_cmd = 3'b000;
        cycles(FILT - 1);
        hi_cmd = 3'b001;
        cycles(15);
        mon_en = 0;
        check("R9 short off-pulse ignored", {6'b0, seen_lo0}, 7'b0);

        // R10 reset clears an upper-side lockout
        hi_cmd = 3'b111;
        cycles(SETTLE);
        hs_uv = 3'b001;
        cycles(SETTLE);
        hs_uv = 3'b000;
        cycles(SETTLE);
        check_out("R8 lockout set before reset", 3'b110, 3'b000, 1'b1);
        rst = 1'b1;
        cycles(3);
        check_out("R10 outputs off in reset", 3'b000, 3'b000, 1'b1);
        rst = 1'b0;
        cycles(SETTLE);
        check_out("R10 reset cleared lockout", 3'b111, 3'b000, 1'b1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule